// File: doc/BRIEF.md
# Multi-output SPI chip-select controller

This block drives up to four active-low chip-select lines for a serial peripheral port. It runs on the serial-port clock. Software writes a control word that holds a mode bit, a level bit and a 2-bit output select. In software mode the level bit drives the selected line directly. In hardware mode the selected line follows a frame-active input that comes from the shifting logic.

The output select passes through a latch. A changed select reaches the pins only two clocks after the write. The level bit acts at once. Because of this, software must write the new select, wait for the settle flag to clear, and only then drive the line active. If it writes the new select and the active level together, the previously latched line goes low for the settle window. A read-only capabilities word reports which lines exist. The number of usable lines is the position of the lowest zero in that mask. Lines at or above that count never go low.

Top module: `cs_select_ctrl`

## Requirements
- R1: A read at reg_addr=1 returns the present-line mask in bits 12:9 (bit 9 is line 0) and zeros in all other bits. With the default parameters this word is 0x00000E00.
- R2: The usable line count is the index of the lowest zero in the mask, or 4 if the mask has no zero. A line whose index is at or above that count stays high at all times.
- R3: At most one of cs_n is low at any time. Every line other than the latched selected line stays high.
- R4: Control bit 0 set to 1 enables software mode. In software mode, control bit 1 sets the level of the latched selected line: 0 drives it low and 1 drives it high. The new level is visible right after the clock edge that takes the write.
- R5: A control write whose bits 9:8 differ from the current requested select latches the new select onto the outputs on the second clock edge after the write edge. settle_busy is high between those two edges. A further select change during that window restarts the two-clock window.
- R6: A control write whose select equals the current requested select leaves settle_busy low and the latched select unchanged.
- R7: During a settle window the previously latched line keeps following the level bit. An active level written together with a new select therefore drives the old line low until the new select is latched.
- R8: With control bit 0 at 0 (hardware mode), the latched selected line is low exactly while frame_active is 1.
- R9: A read at reg_addr=0 returns the mode bit in bit 0, the level bit in bit 1, the requested select in bits 9:8 (updated at once) and settle_busy in bit 16. All other bits read 0.
- R10: After reset the select is 0, the level bit is 1, software mode is off, settle_busy is 0, and with frame_active low all outputs are high.
- R11: Writes to reg_addr=1 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = capabilities word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| frame_active | input | 1 | Hardware frame indicator used in hardware mode |
| cs_n | output | 4 | Active-low chip-select lines |
| settle_busy | output | 1 | High while a select change is still being latched |

## Verification
The bench writes an active level together with a new select. It then checks that the old line, and not the new one, goes low for exactly two cycles. A design that latched the select at once, or one cycle late, would move the low pulse to the wrong line or change its length. It selects line 3 when only three lines exist, which catches a design that ignores the enabled count. It rewrites the select inside the settle window, which catches a design that commits the first value without restarting the window. It also rewrites the same select, which catches a design that sets settle_busy on every write. The bench also toggles frame_active in hardware mode while a select change is still settling. This exposes a design that routes frame_active to the requested line instead of the latched one.

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl #(
  parameter logic [3:0] CS_EN_MASK    = 4'b0111,
  parameter int         SETTLE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        frame_active,
  output logic [3:0]  cs_n,
  output logic        settle_busy
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic          sw_mode, cs_state;
  logic [1:0]    sel_req, sel_act;
  logic [CW-1:0] settle_cnt;
  logic [2:0]    cs_count;
  logic          line_level;
  logic          ctrl_wr;

  assign ctrl_wr = reg_wr && !reg_addr;

  always_comb begin
    cs_count = 3'd4;
    for (int i = 3; i >= 0; i--)
      if (!CS_EN_MASK[i]) cs_count = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mode    <= 1'b0;
      cs_state   <= 1'b1;
      sel_req    <= 2'd0;
      sel_act    <= 2'd0;
      settle_cnt <= '0;
    end else begin
      if (ctrl_wr) begin
        sw_mode  <= reg_wdata[0];
        cs_state <= reg_wdata[1];
      end
      if (ctrl_wr && reg_wdata[9:8] != sel_req) begin
        sel_req    <= reg_wdata[9:8];
        settle_cnt <= CW'(SETTLE_CYCLES);
      end else if (settle_cnt != '0) begin
        settle_cnt <= settle_cnt - CW'(1);
        if (settle_cnt == CW'(1)) sel_act <= sel_req;
      end
    end
  end

  assign settle_busy = (settle_cnt != '0);
  assign line_level  = sw_mode ? cs_state : !frame_active;

  always_comb begin
    cs_n = 4'hF;
    if ({1'b0, sel_act} < cs_count) cs_n[sel_act] = line_level;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[12:9] = CS_EN_MASK;
    end else begin
      reg_rdata[0]    = sw_mode;
      reg_rdata[1]    = cs_state;
      reg_rdata[9:8]  = sel_req;
      reg_rdata[16]   = settle_busy;
    end
  end
endmodule

// File: rtl/cs_select_ctrl_chk.sv
module cs_select_ctrl_chk #(
  parameter logic [3:0] CS_EN_MASK = 4'b0111
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [31:0] reg_wdata,
  input logic        frame_active,
  input logic [3:0]  cs_n,
  input logic        settle_busy,
  input logic        sw_mode,
  input logic        cs_state,
  input logic [1:0]  sel_req,
  input logic [1:0]  sel_act
);
  function automatic int usable(input logic [3:0] m);
    int n = 0;
    while (n < 4 && m[n]) n++;
    return n;
  endfunction

  localparam int        NUSE = usable(CS_EN_MASK);
  localparam logic [3:0] USE_MASK = 4'((1 << NUSE) - 1);

  a_r3_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r2_above_count_high: assert property (@(posedge clk) disable iff (!rst_n)
    &(cs_n | USE_MASK));

  a_r5_busy_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[9:8] != sel_req) |=> settle_busy);

  a_r5_commit_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settle_busy) |-> (sel_act == sel_req));

  a_r6_same_select_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[9:8] == sel_req && !settle_busy) |=> !settle_busy);

  a_r4_sw_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && int'(sel_act) < NUSE) |-> (cs_n[sel_act] == cs_state));

  a_r8_hw_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode && int'(sel_act) < NUSE) |-> (cs_n[sel_act] == !frame_active));
endmodule

bind cs_select_ctrl cs_select_ctrl_chk #(.CS_EN_MASK(CS_EN_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .frame_active(frame_active), .cs_n(cs_n),
  .settle_busy(settle_busy), .sw_mode(sw_mode), .cs_state(cs_state),
  .sel_req(sel_req), .sel_act(sel_act)
);

// File: tb/test_cs_select_ctrl.sv
module test_cs_select_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_active = 1'b0;
  logic [3:0]  cs_n;
  logic        settle_busy;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  cs_select_ctrl i_cs_select_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_active(frame_active),
    .cs_n(cs_n), .settle_busy(settle_busy)
  );

  // {wr, addr, frame, wdata[9:0], exp cs_n, exp busy}
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,10'h003,4'b1111,1'b0}, // R4 sw mode, inactive
    {1'b1,1'b0,1'b0,10'h001,4'b1110,1'b0}, // R4 line 0 low
    {1'b1,1'b0,1'b0,10'h103,4'b1111,1'b1}, // R5 select 1, settling
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b1}, // R5
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b0}, // R5 latched
    {1'b1,1'b0,1'b0,10'h101,4'b1101,1'b0}, // R4 line 1 low
    {1'b1,1'b0,1'b0,10'h103,4'b1111,1'b0}, // R4 line 1 high
    {1'b1,1'b0,1'b0,10'h201,4'b1101,1'b1}, // R7 glitch on old line 1
    {1'b0,1'b0,1'b0,10'h000,4'b1101,1'b1}, // R7
    {1'b0,1'b0,1'b0,10'h000,4'b1011,1'b0}, // R5 line 2 takes over
    {1'b1,1'b0,1'b0,10'h301,4'b1011,1'b1}, // R7 old line 2 stays low
    {1'b0,1'b0,1'b0,10'h000,4'b1011,1'b1}, // R7
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b0}, // R2 line 3 not present
    {1'b1,1'b0,1'b0,10'h002,4'b1111,1'b1}, // R8 hw mode, select 0
    {1'b0,1'b0,1'b1,10'h000,4'b1111,1'b1}, // R8 latched still 3
    {1'b0,1'b0,1'b1,10'h000,4'b1110,1'b0}, // R8 frame drives line 0
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b0}, // R8 frame off
    {1'b1,1'b0,1'b0,10'h001,4'b1110,1'b0}, // R6 same select, no settle
    {1'b1,1'b0,1'b0,10'h103,4'b1111,1'b1}, // R5 select 1
    {1'b1,1'b0,1'b0,10'h203,4'b1111,1'b1}, // R5 restart with select 2
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b1}, // R5
    {1'b0,1'b0,1'b0,10'h000,4'b1111,1'b0}, // R5
    {1'b1,1'b0,1'b0,10'h201,4'b1011,1'b0}, // R3 only line 2 low
    {1'b1,1'b1,1'b0,10'h000,4'b1011,1'b0}  // R11 caps write ignored
  };
  localparam int VREQ [NV] = '{4,4,5,5,5,4,4,7,7,5,7,7,2,8,8,8,8,6,5,5,5,5,3,11};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 cs_n in reset", {28'b0, cs_n}, 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 1'b0;
    chk("R10 control after reset", reg_rdata, 32'h2);
    chk("R10 busy after reset", {31'b0, settle_busy}, 32'h0);
    chk("R10 outputs after reset", {28'b0, cs_n}, 32'hF);
    reg_addr = 1'b1;
    #1;
    chk("R1 capabilities", reg_rdata, 32'h0000_0E00);

    for (int i = 0; i < NV; i++) begin
      reg_wr       = VEC[i][17];
      reg_addr     = VEC[i][16];
      frame_active = VEC[i][15];
      reg_wdata    = {22'b0, VEC[i][14:5]};
      @(negedge clk);
      chk($sformatf("R%0d step %0d cs_n", VREQ[i], i), {28'b0, cs_n}, {28'b0, VEC[i][4:1]});
      chk($sformatf("R%0d step %0d busy", VREQ[i], i), {31'b0, settle_busy}, {31'b0, VEC[i][0]});
    end
    reg_wr = 1'b0;
    reg_addr = 1'b0;
    #1;
    chk("R9 R11 control readback", reg_rdata, 32'h0000_0201);

    reg_wr = 1'b1;
    reg_wdata = 32'h0000_0001;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk("R9 readback while settling", reg_rdata, 32'h0001_0001);
    chk("R7 old line 2 low while settling", {28'b0, cs_n}, 32'hB);

    rst_n = 1'b0;
    #1;
    chk("R10 cs_n on reset", {28'b0, cs_n}, 32'hF);
    chk("R10 control on reset", reg_rdata, 32'h2);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after second reset", {31'b0, settle_busy}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule